// File: doc/BRIEF.md
# Dual-Path Programmable Loop Divider with Reference Step Generator

This block is the division stage of a tuner frequency synthesizer. It divides a variable-frequency input down to the loop comparison rate and, in parallel, divides a master clock down to a selectable channel-step rate. Both results leave the block as single-clock pulses meant for a phase/frequency detector. All inputs are synchronous to the master clock. The variable input comes in as one-cycle tick strobes: one for the band that already passed through a fixed divide-by-16 prescaler outside the block, and one for the band that arrives without prescaling.

A 16-bit division word, a band-select bit and a swallow-enable flag set the variable divider. On the prescaled band only the upper twelve bits of the word count, because the external prescaler already supplies the factor of 16. On the direct band the whole word is the ratio. With the swallow flag set, the direct band runs a pulse-swallow scheme: an internal 16/17 prescale stage works under a swallow counter (low nibble) and a main counter (upper twelve bits). A modulus-control output shows when the stage divides by 17. New control values are taken only at the terminal count, so no output period is ever cut short.

A 3-bit step code picks one of seven reference rates, derived from a 7.2 MHz master clock. Code 7 holds the reference output silent.

Top module: `psd_synth_divider`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `var_pulse`, `ref_pulse` and `mod_ctl` are all low.
- R2: With `sel_am`=0 the block counts only `fm_tick` and emits one `var_pulse` every `div_word[15:4]` ticks. `div_word[3:0]`, `am_tick` and `swallow_en` have no effect, and `mod_ctl` stays low.
- R3: With `sel_am`=0, a value of `div_word[15:4]` below 2 divides by 2.
- R4: With `sel_am`=1 and `swallow_en`=0 the block counts only `am_tick` and emits one `var_pulse` every `div_word` ticks. `mod_ctl` stays low.
- R5: In the direct mode of R4, a `div_word` below 2 divides by 2.
- R6: With `sel_am`=1 and `swallow_en`=1 the ratio is 16·`div_word[15:4]` + `div_word[3:0]` `am_tick` ticks. `mod_ctl` is high for exactly 17·`div_word[3:0]` of those ticks and is low when the cycle ends.
- R7: In swallow mode a `div_word` below 256 divides by 256 with no swallowed ticks.
- R8: The band, swallow flag and division word are adopted only at a terminal count, or once just after reset. A change made mid-cycle leaves the running period intact and applies from the next period on.
- R9: `var_pulse` is one clock wide. It is high in the cycle after the clock edge that takes the terminal tick.
- R10: `ref_code` 0..6 gives a `ref_pulse` period of 288, 576, 1152, 720, 800, 1440 and 7200 clocks (7.2 MHz divided by 25, 12.5, 6.25, 10, 9, 5 and 1 kHz).
- R11: `ref_pulse` is one clock wide. Code 7 stops it once the running period ends. A new code is taken at the reference terminal count, or at once while stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (7.2 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| div_word | input | 16 | Division word, bit 0 least significant |
| sel_am | input | 1 | Band select: 0 prescaled input, 1 direct input |
| swallow_en | input | 1 | Pulse-swallow enable, used only when `sel_am`=1 |
| ref_code | input | 3 | Reference step select, 7 = off |
| fm_tick | input | 1 | One-cycle strobe per edge of the prescaled input |
| am_tick | input | 1 | One-cycle strobe per edge of the direct input |
| var_pulse | output | 1 | Divided variable-frequency pulse |
| ref_pulse | output | 1 | Reference step pulse |
| mod_ctl | output | 1 | High while the swallow stage divides by 17 |

## Verification
The variable divider is tried on both bands. The unused tick input is held constantly active, so counting the wrong source shows up as a wrong ratio. A word with a nonzero low nibble on the prescaled band shows whether the nibble is wrongly used. Swallow words with small and maximal nibbles separate the true 16·M+A count from a plain divide-by-word, and the count of ticks seen with `mod_ctl` high confirms the 17-modulus phase length. Words just under each mode's minimum exercise the clamps. A word change made in mid-period shows whether it is latched at the terminal count or taken at once. Every reference code is timed end to end, and code 7 is watched for a full slow period.

// File: rtl/psd_pkg.sv
package psd_pkg;

  localparam int DIV_W = 16;
  localparam int SW_W  = 4;
  localparam int MCLK_HZ_DEF = 7_200_000;

  typedef enum logic [1:0] {
    MODE_FM         = 2'd0,
    MODE_AM_DIRECT  = 2'd1,
    MODE_AM_SWALLOW = 2'd2
  } div_mode_e;

  function automatic div_mode_e pick_mode(input logic sel_am, input logic sw_en);
    if (!sel_am)    return MODE_FM;
    else if (sw_en) return MODE_AM_SWALLOW;
    else            return MODE_AM_DIRECT;
  endfunction

  // Step rate in Hz for each code; zero marks the stopped code.
  function automatic int unsigned step_hz(input logic [2:0] code);
    case (code)
      3'd0:    return 25000;
      3'd1:    return 12500;
      3'd2:    return 6250;
      3'd3:    return 10000;
      3'd4:    return 9000;
      3'd5:    return 5000;
      3'd6:    return 1000;
      default: return 0;
    endcase
  endfunction

  function automatic int unsigned ref_ratio(input logic [2:0] code, input int unsigned mclk);
    int unsigned s;
    s = step_hz(code);
    return (s == 0) ? 0 : mclk / s;
  endfunction

  // Smallest total ratio the swallow scheme can realise: main count must
  // cover every possible swallow count.
  function automatic int unsigned swallow_min(input int sw_w);
    return (1 << sw_w) * (1 << sw_w);
  endfunction

  // Main-counter ratio after clamping, per mode.
  function automatic int unsigned main_ratio(input div_mode_e m, input int unsigned word,
                                             input int sw_w);
    int unsigned v;
    case (m)
      MODE_FM: begin
        v = word >> sw_w;
        return (v < 2) ? 2 : v;
      end
      MODE_AM_SWALLOW: begin
        v = (word < swallow_min(sw_w)) ? swallow_min(sw_w) : word;
        return v >> sw_w;
      end
      default: return (word < 2) ? 2 : word;
    endcase
  endfunction

  // Swallow count after clamping; zero outside swallow mode.
  function automatic int unsigned swallow_count(input div_mode_e m, input int unsigned word,
                                                input int sw_w);
    if (m != MODE_AM_SWALLOW) return 0;
    if (word < swallow_min(sw_w)) return 0;
    return word & ((1 << sw_w) - 1);
  endfunction

endpackage

// File: rtl/psd_ref_div.sv
module psd_ref_div #(
  parameter int MCLK_HZ = psd_pkg::MCLK_HZ_DEF,
  localparam int CW = $clog2(MCLK_HZ / 1000 + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] code,
  output logic       ref_pulse,
  output logic       ref_term,
  output logic       ref_stop
);
  logic [2:0]    act_code;
  logic [CW-1:0] cnt;
  logic [CW-1:0] reload;
  int unsigned   ratio;

  always_comb begin
    ratio  = psd_pkg::ref_ratio(code, MCLK_HZ);
    reload = (ratio == 0) ? '0 : CW'(ratio - 1);
  end

  assign ref_stop = (psd_pkg::step_hz(act_code) == 0);
  assign ref_term = !ref_stop && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_code  <= 3'd7;
      cnt       <= '0;
      ref_pulse <= 1'b0;
    end else begin
      ref_pulse <= ref_term;
      if (ref_stop || ref_term) begin
        act_code <= code;
        cnt      <= reload;
      end else begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/psd_swallow_stage.sv
// 16/17 prescale stage steered by a swallow counter.
module psd_swallow_stage #(
  parameter int SW_W = psd_pkg::SW_W,
  localparam int PW = SW_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  input  logic            load,
  input  logic [SW_W-1:0] load_val,
  output logic            pre_out,
  output logic            mod_hi
);
  localparam logic [PW-1:0] LONG_LAST  = PW'(1 << SW_W);
  localparam logic [PW-1:0] SHORT_LAST = PW'((1 << SW_W) - 1);

  logic [PW-1:0]   pre_cnt;
  logic [SW_W-1:0] a_cnt;
  logic [SW_W-1:0] a_next;

  assign pre_out = en && tick && (pre_cnt == '0);
  assign mod_hi  = |a_cnt;
  assign a_next  = mod_hi ? a_cnt - 1'b1 : a_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= SHORT_LAST;
      a_cnt   <= '0;
    end else if (load) begin
      a_cnt   <= load_val;
      pre_cnt <= (|load_val) ? LONG_LAST : SHORT_LAST;
    end else if (en && tick) begin
      if (pre_cnt == '0) begin
        a_cnt   <= a_next;
        pre_cnt <= (|a_next) ? LONG_LAST : SHORT_LAST;
      end else begin
        pre_cnt <= pre_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/psd_main_count.sv
module psd_main_count #(
  parameter int W = psd_pkg::DIV_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         term
);
  logic [W-1:0] cnt;

  assign term = step && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (load)                cnt <= load_val;
    else if (step && cnt != '0)   cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/psd_synth_divider.sv
module psd_synth_divider #(
  parameter int DIV_W   = psd_pkg::DIV_W,
  parameter int SW_W    = psd_pkg::SW_W,
  parameter int MCLK_HZ = psd_pkg::MCLK_HZ_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_word,
  input  logic             sel_am,
  input  logic             swallow_en,
  input  logic [2:0]       ref_code,
  input  logic             fm_tick,
  input  logic             am_tick,
  output logic             var_pulse,
  output logic             ref_pulse,
  output logic             mod_ctl
);
  import psd_pkg::*;

  div_mode_e       act_mode;
  div_mode_e       new_mode;
  logic            primed;
  logic            tick_sel;
  logic            is_sw;
  logic            pre_out;
  logic            mod_hi;
  logic            main_step;
  logic            main_term;
  logic [DIV_W-1:0] main_ld;
  logic [SW_W-1:0]  sw_ld;

  // Named events for the checker.
  logic       var_term;
  logic       var_load;
  logic       ref_term;
  logic       ref_stop;
  logic [1:0] act_mode_bits;

  assign tick_sel      = (act_mode == MODE_FM) ? fm_tick : am_tick;
  assign is_sw         = (act_mode == MODE_AM_SWALLOW);
  assign main_step     = is_sw ? pre_out : tick_sel;
  assign var_term      = primed && main_term;
  assign var_load      = var_term || !primed;
  assign mod_ctl       = is_sw && mod_hi;
  assign act_mode_bits = act_mode;

  always_comb begin
    new_mode = pick_mode(sel_am, swallow_en);
    main_ld  = DIV_W'(main_ratio(new_mode, int'(div_word), SW_W) - 1);
    sw_ld    = SW_W'(swallow_count(new_mode, int'(div_word), SW_W));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      act_mode  <= MODE_FM;
      var_pulse <= 1'b0;
    end else begin
      primed    <= 1'b1;
      var_pulse <= var_term;
      if (var_load) act_mode <= new_mode;
    end
  end

  psd_swallow_stage #(.SW_W(SW_W)) u_swallow (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (is_sw),
    .tick     (tick_sel),
    .load     (var_load),
    .load_val (sw_ld),
    .pre_out  (pre_out),
    .mod_hi   (mod_hi)
  );

  psd_main_count #(.W(DIV_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (main_step),
    .load     (var_load),
    .load_val (main_ld),
    .term     (main_term)
  );

  psd_ref_div #(.MCLK_HZ(MCLK_HZ)) u_ref (
    .clk       (clk),
    .rst_n     (rst_n),
    .code      (ref_code),
    .ref_pulse (ref_pulse),
    .ref_term  (ref_term),
    .ref_stop  (ref_stop)
  );
endmodule

// File: rtl/psd_synth_chk.sv
module psd_synth_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fm_tick,
  input logic       am_tick,
  input logic       var_pulse,
  input logic       ref_pulse,
  input logic       mod_ctl,
  input logic       var_term,
  input logic       var_load,
  input logic       ref_stop,
  input logic [1:0] act_mode_bits
);
  // R9
  var_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    var_pulse |=> !var_pulse);

  // R9
  var_pulse_from_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    var_pulse |-> $past(var_term));

  // R9
  term_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    var_term |-> (fm_tick || am_tick));

  // R6
  mod_low_at_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    var_term |-> !mod_ctl);

  // R8
  mode_change_at_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode_bits != $past(act_mode_bits)) |-> $past(var_load));

  // R11
  ref_pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |=> !ref_pulse);

  // R11
  ref_stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_stop |=> !ref_pulse);
endmodule

bind psd_synth_divider psd_synth_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fm_tick       (fm_tick),
  .am_tick       (am_tick),
  .var_pulse     (var_pulse),
  .ref_pulse     (ref_pulse),
  .mod_ctl       (mod_ctl),
  .var_term      (var_term),
  .var_load      (var_load),
  .ref_stop      (ref_stop),
  .act_mode_bits (act_mode_bits)
);

// File: tb/tb_psd_synth_divider.sv
module tb_psd_synth_divider;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] div_word = 16'd0;
  logic        sel_am = 1'b0;
  logic        swallow_en = 1'b0;
  logic [2:0]  ref_code = 3'd0;
  logic        fm_tick = 1'b0;
  logic        am_tick = 1'b0;
  logic        var_pulse, ref_pulse, mod_ctl;

  psd_synth_divider dut (
    .clk(clk), .rst_n(rst_n), .div_word(div_word), .sel_am(sel_am),
    .swallow_en(swallow_en), .ref_code(ref_code), .fm_tick(fm_tick),
    .am_tick(am_tick), .var_pulse(var_pulse), .ref_pulse(ref_pulse),
    .mod_ctl(mod_ctl)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit tb_sel = 1'b0;
  bit phase = 1'b0;
  int tick_cnt = 0, mod_cnt = 0, last_int = 0, last_mod = 0, pulse_cnt = 0;
  int ref_gap = 0, last_ref_gap = 0, ref_cnt = 0;
  int wide_var = 0, wide_ref = 0;
  bit prev_vp = 1'b0, prev_rp = 1'b0;
  int cycles = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Stimulus generator and observer, all at the falling edge.
  // The selected tick source strobes every other cycle; the other stays high.
  initial begin
    forever begin
      @(negedge clk);
      cycles++;
      if (var_pulse) begin
        if (prev_vp) wide_var++;
        last_int = tick_cnt; last_mod = mod_cnt;
        tick_cnt = 0; mod_cnt = 0; pulse_cnt++;
      end
      prev_vp = var_pulse;
      ref_gap++;
      if (ref_pulse) begin
        if (prev_rp) wide_ref++;
        last_ref_gap = ref_gap; ref_gap = 0; ref_cnt++;
      end
      prev_rp = ref_pulse;
      phase = !phase;
      if (phase) begin
        tick_cnt++;
        if (mod_ctl) mod_cnt++;
      end
      fm_tick = tb_sel ? 1'b1 : phase;
      am_tick = tb_sel ? phase : 1'b1;
    end
  end

  task automatic wait_vp(input int n);
    int target;
    target = pulse_cnt + n;
    while (pulse_cnt < target) @(negedge clk);
  endtask

  task automatic wait_rp(input int n);
    int target;
    target = ref_cnt + n;
    while (ref_cnt < target) @(negedge clk);
  endtask

  task automatic set_var(input bit am, input bit sw, input int word);
    @(negedge clk);
    sel_am = am; tb_sel = am; swallow_en = sw; div_word = 16'(word);
  endtask

  task automatic ratio_case(input bit am, input bit sw, input int word,
                            input int exp_n, input int exp_mod, input string req);
    set_var(am, sw, word);
    wait_vp(2);
    chk(last_int == exp_n, req, last_int, exp_n);
    chk(last_mod == exp_mod, req, last_mod, exp_mod);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk(!var_pulse && !ref_pulse && !mod_ctl, "R1 in reset", 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!var_pulse && !ref_pulse && !mod_ctl, "R1 after release",
        int'({var_pulse, ref_pulse, mod_ctl}), 0);
  endtask

  task automatic t_fm();
    ratio_case(1'b0, 1'b0, 16'h0123, 18, 0, "R2 fm ratio");
    ratio_case(1'b0, 1'b0, 16'h012F, 18, 0, "R2 low nibble ignored");
    ratio_case(1'b0, 1'b1, 16'h0123, 18, 0, "R2 swallow flag ignored");
    ratio_case(1'b0, 1'b0, 16'h001F, 2, 0, "R3 fm clamp from 1");
    ratio_case(1'b0, 1'b0, 16'h0000, 2, 0, "R3 fm clamp from 0");
  endtask

  task automatic t_am_direct();
    ratio_case(1'b1, 1'b0, 300, 300, 0, "R4 direct ratio");
    ratio_case(1'b1, 1'b0, 37, 37, 0, "R4 direct odd ratio");
    ratio_case(1'b1, 1'b0, 1, 2, 0, "R5 direct clamp from 1");
    ratio_case(1'b1, 1'b0, 0, 2, 0, "R5 direct clamp from 0");
  endtask

  task automatic t_swallow();
    ratio_case(1'b1, 1'b1, 16*20 + 5, 325, 85, "R6 swallow 20/5");
    ratio_case(1'b1, 1'b1, 16*16 + 15, 271, 255, "R6 swallow 16/15");
    ratio_case(1'b1, 1'b1, 16*30, 480, 0, "R6 swallow nibble 0");
    ratio_case(1'b1, 1'b1, 100, 256, 0, "R7 swallow clamp 100");
    ratio_case(1'b1, 1'b1, 255, 256, 0, "R7 swallow clamp 255");
  endtask

  task automatic t_latch();
    ratio_case(1'b1, 1'b0, 40, 40, 0, "R8 setup");
    repeat (20) @(negedge clk);
    div_word = 16'd60;
    wait_vp(1);
    chk(last_int == 40, "R8 running period kept", last_int, 40);
    wait_vp(1);
    chk(last_int == 60, "R8 new word applied", last_int, 60);
    chk(wide_var == 0, "R9 var pulse width", wide_var, 0);
  endtask

  task automatic t_ref();
    int exp_gap [7] = '{288, 576, 1152, 720, 800, 1440, 7200};
    for (int c = 0; c < 7; c++) begin
      ref_code = 3'(c);
      wait_rp(3);
      chk(last_ref_gap == exp_gap[c], $sformatf("R10 code %0d", c), last_ref_gap, exp_gap[c]);
    end
    ref_code = 3'd7;
    wait_rp(1);
    begin
      int seen;
      seen = ref_cnt;
      repeat (8000) @(negedge clk);
      chk(ref_cnt == seen, "R11 code 7 silent", ref_cnt - seen, 0);
    end
    ref_code = 3'd0;
    wait_rp(3);
    chk(last_ref_gap == 288, "R11 restart from stop", last_ref_gap, 288);
    chk(wide_ref == 0, "R11 ref pulse width", wide_ref, 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_fm();
    t_am_direct();
    t_swallow();
    t_latch();
    t_ref();
    finish_run();
  end

  initial begin
    wait (cycles >= WATCHDOG);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cycles, WATCHDOG);
    finish_run();
  end
endmodule